// File: doc/BRIEF.md
# Privileged System Register File

This block keeps the machine-state registers of a protected-mode core: a 32-bit flags word with an interrupt-enable bit, a two-bit I/O privilege level and a nested-task bit; a global descriptor-table register (base and limit); a local descriptor-table register (selector, base, limit and attributes); and a control word with protection-enable and paging-enable bits.

The execution unit presents one write request per cycle. Each request carries an instruction class (flag pop, interrupt return, table load or control write), the current privilege level and the data to write. The block checks the request against the privilege rules and the rules that tie fields together. It then applies the legal parts of the write or reports a general-protection fault. It also shows, without waiting for a clock edge, whether the current privilege level may reach I/O space.

Top module: `sysreg_file`

## Requirements
- R1: After a synchronous reset the flags word reads 0x00000002 and the control word reads 0. The global table has base 0 and limit 0xFFFF. The local table has selector 0, base 0, limit 0xFFFF and attributes 0. No fault is shown.
- R2: On a flag pop (class 0) or interrupt return (class 1), the interrupt-enable bit (bit 9) takes the written value only when the current privilege level is less than or equal to the stored I/O privilege level. Otherwise it keeps its old value and no fault is raised.
- R3: On a flag pop or interrupt return, the I/O privilege field (bits 13:12) takes the written value only at privilege level 0. At any other level it keeps its old value.
- R4: On a flag pop or interrupt return, the nested-task bit (bit 14) takes the written value at any privilege level.
- R5: In the flags word, bit 1 always reads 1. Every bit other than 1, 9, 12, 13 and 14 reads 0, whatever is written.
- R6: `io_ok` is 1 exactly when the `cpl` input is numerically less than or equal to the stored I/O privilege level.
- R7: A table load (class 2) at privilege level 0 does the following. With `wr_local`=0 it replaces the global base and limit. With `wr_local`=1 it replaces the local selector, base, limit and attributes together on one clock edge.
- R8: A table load at a privilege level other than 0 changes no table register and raises a fault with cause 1.
- R9: A control write (class 3) whose data has bit 31 (paging) set and bit 0 (protection) clear raises a fault with cause 3 and leaves the control word unchanged.
- R10: A control write at a privilege level other than 0 raises a fault with cause 2 and leaves the control word unchanged. This cause takes priority over cause 3. An accepted control write stores only bits 0 and 31; all other bits read 0.
- R11: An accepted write is visible on the outputs after the next rising clock edge. A fault shows as `fault_valid`=1 for exactly the cycle after the offending request, together with its cause. When there is no fault, `fault_valid`=0 and `fault_cause`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request present this cycle |
| wr_class | input | 2 | 0 flag pop, 1 interrupt return, 2 table load, 3 control write |
| wr_local | input | 1 | Table load target: 0 global, 1 local |
| cpl | input | 2 | Current privilege level |
| wr_data | input | 32 | Data for flags or control writes |
| tbl_sel | input | 16 | Selector for a local table load |
| tbl_base | input | 32 | Base for a table load |
| tbl_limit | input | 16 | Limit for a table load |
| tbl_attr | input | 8 | Attributes for a local table load |
| flags_q | output | 32 | Flags word |
| ctrl_q | output | 32 | Control word |
| gtab_base | output | 32 | Global table base |
| gtab_limit | output | 16 | Global table limit |
| ltab_sel | output | 16 | Local table selector |
| ltab_base | output | 32 | Local table base |
| ltab_limit | output | 16 | Local table limit |
| ltab_attr | output | 8 | Local table attributes |
| io_ok | output | 1 | I/O access permitted at `cpl` |
| fault_valid | output | 1 | General-protection fault pulse |
| fault_cause | output | 2 | 0 none, 1 table-load privilege, 2 control privilege, 3 paging without protection |

## Verification
Flag writes are issued at privilege levels 0, 2 and 3 against stored I/O levels of 3 and 0. This separates the rule for the interrupt-enable bit (level compared with the I/O level) from the rule for the I/O field (level 0 only) and from the nested-task bit, which is always writable. An all-ones data word shows that reserved bits stay at zero. Control writes cover four cases: legal, paging without protection, unprivileged, and unprivileged together with illegal paging. Together they fix the order of precedence between the fault causes. Global and local table loads use distinct field patterns and alternate between privileged and unprivileged levels, so the tests show both that all local fields change together and that an unprivileged load is blocked.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
    parameter int REG_W  = 32;
    parameter int ADDR_W = 32;
    parameter int LIM_W  = 16;
    parameter int SEL_W  = 16;
    parameter int ATTR_W = 8;
    parameter int PL_W   = 2;

    localparam int IE_BIT   = 9;
    localparam int IOPL_LO  = 12;
    localparam int NT_BIT   = 14;
    localparam int ONE_BIT  = 1;
    localparam int PE_BIT   = 0;
    localparam int PG_BIT   = 31;

    localparam logic [LIM_W-1:0] LIM_RST   = '1;
    localparam logic [REG_W-1:0] CTRL_MASK = (REG_W'(1) << PG_BIT) | (REG_W'(1) << PE_BIT);

    typedef enum logic [1:0] {
        CLS_FLAGPOP = 2'd0,
        CLS_IRET    = 2'd1,
        CLS_TBLLOAD = 2'd2,
        CLS_CTRLWR  = 2'd3
    } wr_class_e;

    typedef enum logic [1:0] {
        FLT_NONE      = 2'd0,
        FLT_TBL_PRIV  = 2'd1,
        FLT_CTRL_PRIV = 2'd2,
        FLT_PG_NO_PE  = 2'd3
    } fault_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic [ATTR_W-1:0] attr;
    } tbl_reg_t;

    function automatic logic io_allowed(input logic [PL_W-1:0] lvl,
                                        input logic [PL_W-1:0] iopl);
        return lvl <= iopl;
    endfunction

    function automatic logic [REG_W-1:0] flags_pack(input logic ie,
                                                    input logic [PL_W-1:0] iopl,
                                                    input logic nt);
        logic [REG_W-1:0] w;
        w = '0;
        w[ONE_BIT] = 1'b1;
        w[IE_BIT]  = ie;
        w[IOPL_LO +: PL_W] = iopl;
        w[NT_BIT]  = nt;
        return w;
    endfunction
endpackage

// File: rtl/sysreg_flags.sv
module sysreg_flags
    import sysreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [PL_W-1:0]     cpl,
    input  logic                ie_d,
    input  logic [PL_W-1:0]     iopl_d,
    input  logic                nt_d,
    output logic [REG_W-1:0]    flags_q,
    output logic [PL_W-1:0]     iopl_q
);
    logic ie_r, nt_r;
    logic [PL_W-1:0] iopl_r;
    logic ie_ok, iopl_ok;

    assign ie_ok   = io_allowed(cpl, iopl_r);
    assign iopl_ok = (cpl == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_r   <= 1'b0;
            iopl_r <= '0;
            nt_r   <= 1'b0;
        end else if (wr_en) begin
            if (ie_ok)   ie_r   <= ie_d;
            if (iopl_ok) iopl_r <= iopl_d;
            nt_r <= nt_d;
        end
    end

    assign flags_q = flags_pack(ie_r, iopl_r, nt_r);
    assign iopl_q  = iopl_r;

    AST_IE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (cpl > iopl_r)) |=> $stable(flags_q[IE_BIT])); // R2
    AST_IOPL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (cpl != '0)) |=> $stable(iopl_q)); // R3
    AST_FLAG_ONE: assert property (@(posedge clk) disable iff (rst)
        flags_q[ONE_BIT]); // R5
endmodule

// File: rtl/sysreg_dtab.sv
module sysreg_dtab
    import sysreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_req,
    input  logic              ld_local,
    input  logic [PL_W-1:0]   cpl,
    input  tbl_reg_t          ld_val,
    output logic [ADDR_W-1:0] g_base,
    output logic [LIM_W-1:0]  g_limit,
    output tbl_reg_t          l_q,
    output logic              flt_priv
);
    logic priv_ok;
    assign priv_ok  = (cpl == '0);
    assign flt_priv = ld_req && !priv_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            g_base  <= '0;
            g_limit <= LIM_RST;
            l_q     <= '{sel: '0, base: '0, limit: LIM_RST, attr: '0};
        end else if (ld_req && priv_ok) begin
            if (ld_local) begin
                l_q <= ld_val;
            end else begin
                g_base  <= ld_val.base;
                g_limit <= ld_val.limit;
            end
        end
    end

    AST_TBL_LOCKED: assert property (@(posedge clk) disable iff (rst)
        flt_priv |=> ($stable(g_base) && $stable(g_limit) && $stable(l_q))); // R8
endmodule

// File: rtl/sysreg_ctrl.sv
module sysreg_ctrl
    import sysreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_req,
    input  logic [PL_W-1:0]  cpl,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctrl_q,
    output logic             flt_priv,
    output logic             flt_pg
);
    logic [REG_W-1:0] masked;
    assign masked   = wdata & CTRL_MASK;
    assign flt_priv = wr_req && (cpl != '0);
    assign flt_pg   = wr_req && masked[PG_BIT] && !masked[PE_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_req && !flt_priv && !flt_pg) begin
            ctrl_q <= masked;
        end
    end

    AST_PG_NEEDS_PE: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[PG_BIT] |-> ctrl_q[PE_BIT]); // R9
    AST_CTRL_PRIV: assert property (@(posedge clk) disable iff (rst)
        flt_priv |=> $stable(ctrl_q)); // R10
endmodule

// File: rtl/sysreg_file.sv
module sysreg_file
    import sysreg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_valid,
    input  logic [1:0]              wr_class,
    input  logic                    wr_local,
    input  logic [PL_W-1:0]         cpl,
    input  logic [REG_W-1:0]        wr_data,
    input  logic [SEL_W-1:0]        tbl_sel,
    input  logic [ADDR_W-1:0]       tbl_base,
    input  logic [LIM_W-1:0]        tbl_limit,
    input  logic [ATTR_W-1:0]       tbl_attr,
    output logic [REG_W-1:0]        flags_q,
    output logic [REG_W-1:0]        ctrl_q,
    output logic [ADDR_W-1:0]       gtab_base,
    output logic [LIM_W-1:0]        gtab_limit,
    output logic [SEL_W-1:0]        ltab_sel,
    output logic [ADDR_W-1:0]       ltab_base,
    output logic [LIM_W-1:0]        ltab_limit,
    output logic [ATTR_W-1:0]       ltab_attr,
    output logic                    io_ok,
    output logic                    fault_valid,
    output logic [1:0]              fault_cause
);
    wr_class_e cls;
    logic      flag_wr, tbl_wr, ctrl_wr;
    logic [PL_W-1:0] iopl_cur;
    logic      tbl_flt, ctrl_flt_priv, ctrl_flt_pg;
    tbl_reg_t  ld_val, l_cur;
    fault_e    flt_next, flt_q;

    assign cls     = wr_class_e'(wr_class);
    assign flag_wr = wr_valid && (cls == CLS_FLAGPOP || cls == CLS_IRET);
    assign tbl_wr  = wr_valid && (cls == CLS_TBLLOAD);
    assign ctrl_wr = wr_valid && (cls == CLS_CTRLWR);
    assign ld_val  = '{sel: tbl_sel, base: tbl_base, limit: tbl_limit, attr: tbl_attr};

    sysreg_flags u_flags (
        .clk(clk), .rst(rst), .wr_en(flag_wr), .cpl(cpl),
        .ie_d(wr_data[IE_BIT]), .iopl_d(wr_data[IOPL_LO +: PL_W]),
        .nt_d(wr_data[NT_BIT]), .flags_q(flags_q), .iopl_q(iopl_cur)
    );

    sysreg_dtab u_dtab (
        .clk(clk), .rst(rst), .ld_req(tbl_wr), .ld_local(wr_local), .cpl(cpl),
        .ld_val(ld_val), .g_base(gtab_base), .g_limit(gtab_limit),
        .l_q(l_cur), .flt_priv(tbl_flt)
    );

    sysreg_ctrl u_ctrl (
        .clk(clk), .rst(rst), .wr_req(ctrl_wr), .cpl(cpl), .wdata(wr_data),
        .ctrl_q(ctrl_q), .flt_priv(ctrl_flt_priv), .flt_pg(ctrl_flt_pg)
    );

    always_comb begin
        if (tbl_flt)            flt_next = FLT_TBL_PRIV;
        else if (ctrl_flt_priv) flt_next = FLT_CTRL_PRIV;
        else if (ctrl_flt_pg)   flt_next = FLT_PG_NO_PE;
        else                    flt_next = FLT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) flt_q <= FLT_NONE;
        else     flt_q <= flt_next;
    end

    assign fault_valid = (flt_q != FLT_NONE);
    assign fault_cause = flt_q;
    assign io_ok       = io_allowed(cpl, iopl_cur);
    assign ltab_sel    = l_cur.sel;
    assign ltab_base   = l_cur.base;
    assign ltab_limit  = l_cur.limit;
    assign ltab_attr   = l_cur.attr;

    AST_FAULT_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> $past(wr_valid)); // R11
    AST_FLAG_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        (flag_wr) |=> !fault_valid); // R2
endmodule

// File: tb/sysreg_file_test.sv
`timescale 1ns/1ps
module sysreg_file_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        wr_valid = 0, wr_local = 0;
    logic [1:0]  wr_class = 0, cpl = 0;
    logic [31:0] wr_data = 0, tbl_base = 0;
    logic [15:0] tbl_sel = 0, tbl_limit = 0;
    logic [7:0]  tbl_attr = 0;
    logic [31:0] flags_q, ctrl_q, gtab_base, ltab_base;
    logic [15:0] gtab_limit, ltab_sel, ltab_limit;
    logic [7:0]  ltab_attr;
    logic        io_ok, fault_valid;
    logic [1:0]  fault_cause;

    sysreg_file uut (.*);

    typedef struct {
        logic [31:0] flags, ctrl, gbase, lbase;
        logic [15:0] glim, lsel, llim;
        logic [7:0]  lattr;
        logic        io, fv;
        logic [1:0]  fc;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic        m_ie, m_nt;
    logic [1:0]  m_iopl;
    logic [31:0] m_ctrl, m_gbase, m_lbase;
    logic [15:0] m_glim, m_lsel, m_llim;
    logic [7:0]  m_lattr;

    function automatic logic [31:0] mflags();
        return 32'h2 | (32'(m_ie) << 9) | (32'(m_iopl) << 12) | (32'(m_nt) << 14);
    endfunction

    task automatic model_reset();
        m_ie = 0; m_nt = 0; m_iopl = 0; m_ctrl = 0;
        m_gbase = 0; m_glim = 16'hFFFF; m_lsel = 0; m_lbase = 0;
        m_llim = 16'hFFFF; m_lattr = 0;
    endtask

    task automatic op(input logic v, input logic [1:0] c, input logic [1:0] lvl,
                      input logic [31:0] d, input logic loc, input logic [15:0] s,
                      input logic [31:0] b, input logic [15:0] l, input logic [7:0] a,
                      input string tag);
        exp_t e;
        logic [1:0] fc;
        @(negedge clk);
        wr_valid = v; wr_class = c; cpl = lvl; wr_data = d; wr_local = loc;
        tbl_sel = s; tbl_base = b; tbl_limit = l; tbl_attr = a;
        fc = 0;
        if (v) begin
            case (c)
                2'd0, 2'd1: begin
                    if (lvl <= m_iopl) m_ie = d[9];
                    if (lvl == 0) m_iopl = d[13:12];
                    m_nt = d[14];
                end
                2'd2: begin
                    if (lvl != 0) fc = 1;
                    else if (loc) begin m_lsel = s; m_lbase = b; m_llim = l; m_lattr = a; end
                    else begin m_gbase = b; m_glim = l; end
                end
                default: begin
                    if (lvl != 0) fc = 2;
                    else if (d[31] && !d[0]) fc = 3;
                    else m_ctrl = d & 32'h8000_0001;
                end
            endcase
        end
        e.flags = mflags(); e.ctrl = m_ctrl; e.gbase = m_gbase; e.glim = m_glim;
        e.lsel = m_lsel; e.lbase = m_lbase; e.llim = m_llim; e.lattr = m_lattr;
        e.io = (lvl <= m_iopl); e.fv = (fc != 0); e.fc = fc; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input logic [1:0] lvl, input string tag);
        op(0, 0, lvl, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (!rst && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (flags_q !== e.flags || ctrl_q !== e.ctrl || gtab_base !== e.gbase ||
                    gtab_limit !== e.glim || ltab_sel !== e.lsel || ltab_base !== e.lbase ||
                    ltab_limit !== e.llim || ltab_attr !== e.lattr || io_ok !== e.io ||
                    fault_valid !== e.fv || fault_cause !== e.fc) begin
                    n_bad++;
                    $display("FAIL %s: got flags=%h ctrl=%h g=%h/%h l=%h/%h/%h/%h io=%b f=%b/%0d exp flags=%h ctrl=%h g=%h/%h l=%h/%h/%h/%h io=%b f=%b/%0d",
                        e.tag, flags_q, ctrl_q, gtab_base, gtab_limit, ltab_sel, ltab_base,
                        ltab_limit, ltab_attr, io_ok, fault_valid, fault_cause,
                        e.flags, e.ctrl, e.gbase, e.glim, e.lsel, e.lbase, e.llim, e.lattr,
                        e.io, e.fv, e.fc);
                end
            end
        end
    end

    initial begin : watchdog
        #(4 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : driver
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        idle(0, "R1 reset state");
        op(1, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R5 R3 R2 R4 pop at level 0 all ones");
        op(1, 1, 3, 32'h0000_0000, 0, 0, 0, 0, 0, "R3 R2 R4 iret at level 3 keeps iopl");
        op(1, 0, 0, 32'h0000_0200, 0, 0, 0, 0, 0, "R3 iopl lowered at level 0");
        op(1, 0, 2, 32'h0000_7000, 0, 0, 0, 0, 0, "R2 R3 R6 level 2 above iopl");
        idle(0, "R6 io allowed at level 0");
        op(1, 2, 0, 0, 0, 16'h1111, 32'hA5A5_0000, 16'h0123, 8'h77, "R7 global load");
        op(1, 2, 0, 0, 1, 16'h0048, 32'h1234_5678, 16'h00FF, 8'h82, "R7 local load all fields");
        op(1, 2, 1, 0, 1, 16'hBEEF, 32'hDEAD_0000, 16'h0001, 8'h11, "R8 local load at level 1");
        op(1, 2, 3, 0, 0, 16'h0, 32'hFFFF_0000, 16'h0002, 8'h0, "R8 global load at level 3");
        idle(0, "R11 fault clears");
        op(1, 3, 0, 32'h8000_0000, 0, 0, 0, 0, 0, "R9 paging without protection");
        op(1, 3, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R10 R11 legal control write masked");
        op(1, 3, 3, 32'h0000_0000, 0, 0, 0, 0, 0, "R10 control write at level 3");
        op(1, 3, 2, 32'h8000_0000, 0, 0, 0, 0, 0, "R10 priority over paging fault");
        op(1, 3, 0, 32'h0000_0001, 0, 0, 0, 0, 0, "R10 paging cleared");
        op(1, 3, 0, 32'h8000_0000, 0, 0, 0, 0, 0, "R9 paging needs written protection");
        op(1, 1, 0, 32'h0000_3200, 0, 0, 0, 0, 0, "R3 R6 iopl raised to 3");
        idle(3, "R6 io allowed at level 3");
        op(1, 0, 3, 32'h0000_4000, 0, 0, 0, 0, 0, "R2 R4 level 3 clears ie sets nt");
        idle(1, "R11 no fault after flag write");
        idle(0, "R11 drain");
        repeat (3) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule